// File: doc/BRIEF.md
# Tour Crossover and Swap Mutation Operator

This block is one genetic operator for tour chromosomes. A tour is a sequence of city indices in which every city occurs exactly once. The block takes two parent tours and builds one child tour that is itself a valid tour. It then, if asked, exchanges the cities held at two random positions. A start pulse launches one operation. A done pulse marks the cycle in which the child output is valid. The child then holds its value until the next operation.

The child is built in steps. A random cut position is drawn first. The first parent's genes up to and including the cut are copied into the same positions of the child. A bitmap of free cities records which cities are still unused. Each position right of the cut is then visited in order. The second parent's city at that position is taken only if it is still free; otherwise the position is marked as a hole. The holes are then filled from left to right, one per cycle. Each hole takes the (r mod k)-th free city, where k is the number of free cities and r is a random number. Three free-running LFSRs provide the cut, the fill choice and the two swap positions.

Top module: `gaTourXover`

## Requirements
- R1: After reset, `done` is low and `child` is all zeros.
- R2: Whenever `done` is high, `child` holds every city index 0..N_CITY-1 exactly once. Gene i of a tour vector sits at bits [i*IDX_W +: IDX_W], and position 0 is the head.
- R3: With `mutEn` low, there is a cut c in 0..N_CITY-1 such that child positions 0..c equal `parentA` positions 0..c.
- R4: With `mutEn` low, for every position j greater than that cut, child gene j equals `parentB` gene j whenever that city is not among `parentA` genes 0..c.
- R5: Positions left as holes after the scan are filled with cities that no earlier position holds. No hole remains when `done` rises, even when most right-side genes of `parentB` collide.
- R6: With `mutEn` high, the child differs from the crossover result in either zero positions (the two drawn positions coincide) or exactly two positions whose cities are exchanged.
- R7: With `mutEn` low and both parents equal, the child equals that parent.
- R8: `done` is a single-cycle pulse. A `start` pulse that arrives while an operation is running is ignored and produces no second `done`.
- R9: Between operations, `child` stays stable whatever happens on the parent and mode inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launches one operation when the block is idle |
| mutEn | input | 1 | Enables the swap mutation for this operation |
| parentA | input | N_CITY*IDX_W | First parent tour; supplies the head segment |
| parentB | input | N_CITY*IDX_W | Second parent tour; supplies the tail where free |
| done | output | 1 | One-cycle pulse when `child` is valid |
| child | output | N_CITY*IDX_W | Resulting tour |

## Verification
The cut position and the fill choices are internal random values, so the exact child cannot be predicted from the ports. The bench therefore searches all possible cuts for one that agrees with the child. The hardest case is a scan in which most of the second parent's tail collides with the copied head, which forces many holes and several random fill cycles. The bench brings this about with identity and reversed parents and with rotated parents, so that nearly every tail city is already taken. Equal parents make the crossover result exactly known, so any mutation can be seen as a pure exchange of two positions.

// File: rtl/gaTourPkg.sv
package gaTourPkg;

  typedef struct packed {
    logic load;
    logic scan;
    logic fill;
    logic mutate;
  } tourStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_SCAN,
    ST_FILL,
    ST_MUT,
    ST_DONE
  } tourState_t;

endpackage

// File: rtl/gaLfsr.sv
module gaLfsr #(
  parameter int WIDTH = 16,
  parameter logic [WIDTH-1:0] TAPS = 16'hB400,
  parameter logic [WIDTH-1:0] SEED = 16'hACE1
) (
  input  logic             clk,
  input  logic             rstN,
  output logic [WIDTH-1:0] value
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) value <= SEED;
    else       value <= {1'b0, value[WIDTH-1:1]} ^ (value[0] ? TAPS : '0);
  end

endmodule

// File: rtl/gaTourCtrl.sv
module gaTourCtrl
  import gaTourPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        mutEn,
  input  logic        scanPending,
  input  logic        scanLast,
  input  logic        noHoles,
  output tourStrobe_t ctl,
  output logic        done
);

  tourState_t state, stateNext;
  logic mutReq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      mutReq <= 1'b0;
    end else begin
      state <= stateNext;
      if (state == ST_IDLE && start) mutReq <= mutEn;
    end
  end

  always_comb begin
    stateNext = state;
    ctl       = '0;
    unique case (state)
      ST_IDLE: if (start) stateNext = ST_LOAD;
      ST_LOAD: begin
        ctl.load  = 1'b1;
        stateNext = ST_SCAN;
      end
      ST_SCAN: begin
        ctl.scan = scanPending;
        if (!scanPending || scanLast) stateNext = ST_FILL;
      end
      ST_FILL: begin
        ctl.fill = !noHoles;
        if (noHoles) stateNext = ST_MUT;
      end
      ST_MUT: begin
        ctl.mutate = mutReq;
        stateNext  = ST_DONE;
      end
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  assign done = (state == ST_DONE);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN) done |=> !done);
  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |=> (state != ST_LOAD));
  // R5
  done_no_holes_chk: assert property (@(posedge clk) disable iff (!rstN) done |-> noHoles);

endmodule

// File: rtl/gaTourPath.sv
module gaTourPath
  import gaTourPkg::*;
#(
  parameter int N_CITY = 8,
  parameter int IDX_W  = $clog2(N_CITY),
  parameter int RND_W  = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  tourStrobe_t               ctl,
  input  logic [N_CITY*IDX_W-1:0]   parentA,
  input  logic [N_CITY*IDX_W-1:0]   parentB,
  input  logic [RND_W-1:0]          rndCut,
  input  logic [RND_W-1:0]          rndFill,
  input  logic [RND_W-1:0]          rndSwap,
  output logic [N_CITY*IDX_W-1:0]   child,
  output logic                      scanPending,
  output logic                      scanLast,
  output logic                      noHoles
);

  localparam logic [RND_W-1:0] N_R     = RND_W'(N_CITY);
  localparam int               HALF_W  = RND_W / 2;
  localparam logic [IDX_W-1:0] LAST_IX = IDX_W'(N_CITY - 1);

  logic [IDX_W-1:0]  childR [N_CITY];
  logic [IDX_W-1:0]  geneB  [N_CITY];
  logic [IDX_W-1:0]  geneA  [N_CITY];
  logic [N_CITY-1:0] pool, holes;
  logic [IDX_W-1:0]  pos;

  logic [IDX_W-1:0]  cut;
  logic [N_CITY-1:0] poolLoad;
  logic [IDX_W-1:0]  firstHole;
  logic [RND_W-1:0]  freeCount, target, seen;
  logic [IDX_W-1:0]  pick;
  logic [IDX_W-1:0]  swapP, swapQ;
  logic [IDX_W-1:0]  scanGene;

  for (genvar g = 0; g < N_CITY; g++) begin : g_unpack
    assign geneA[g] = parentA[g*IDX_W +: IDX_W];
    assign child[g*IDX_W +: IDX_W] = childR[g];
  end

  assign cut      = IDX_W'(rndCut % N_R);
  assign swapP    = IDX_W'(RND_W'(rndSwap[HALF_W-1:0]) % N_R);
  assign swapQ    = IDX_W'(RND_W'(rndSwap[RND_W-1:HALF_W]) % N_R);
  assign scanGene = geneB[pos];
  assign scanLast = (pos == LAST_IX);
  assign noHoles  = (holes == '0);

  always_comb begin
    poolLoad = '1;
    for (int i = 0; i < N_CITY; i++)
      if (IDX_W'(i) <= cut) poolLoad[geneA[i]] = 1'b0;
  end

  always_comb begin
    firstHole = '0;
    for (int i = N_CITY - 1; i >= 0; i--)
      if (holes[i]) firstHole = IDX_W'(i);
  end

  always_comb begin
    freeCount = '0;
    for (int j = 0; j < N_CITY; j++) freeCount = freeCount + RND_W'(pool[j]);
    target = rndFill % ((freeCount == '0) ? RND_W'(1) : freeCount);
    seen   = '0;
    pick   = '0;
    for (int j = 0; j < N_CITY; j++) begin
      if (pool[j]) begin
        if (seen == target) pick = IDX_W'(j);
        seen = seen + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pool        <= '0;
      holes       <= '0;
      pos         <= '0;
      scanPending <= 1'b0;
      for (int i = 0; i < N_CITY; i++) begin
        childR[i] <= '0;
        geneB[i]  <= '0;
      end
    end else if (ctl.load) begin
      pool        <= poolLoad;
      pos         <= (cut == LAST_IX) ? cut : cut + 1'b1;
      scanPending <= (cut != LAST_IX);
      for (int i = 0; i < N_CITY; i++) begin
        geneB[i]  <= parentB[i*IDX_W +: IDX_W];
        childR[i] <= (IDX_W'(i) <= cut) ? geneA[i] : '0;
        holes[i]  <= (IDX_W'(i) > cut);
      end
    end else if (ctl.scan) begin
      if (pool[scanGene]) begin
        childR[pos]     <= scanGene;
        pool[scanGene]  <= 1'b0;
        holes[pos]      <= 1'b0;
      end
      if (scanLast) scanPending <= 1'b0;
      else          pos <= pos + 1'b1;
    end else if (ctl.fill) begin
      childR[firstHole] <= pick;
      holes[firstHole]  <= 1'b0;
      pool[pick]        <= 1'b0;
    end else if (ctl.mutate) begin
      childR[swapP] <= childR[swapQ];
      childR[swapQ] <= childR[swapP];
    end
  end

  // R2
  pool_hole_balance_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(pool) == $countones(holes));
  // R9
  child_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.load || ctl.scan || ctl.fill || ctl.mutate) |=> $stable(child));
  // R5
  fill_progress_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.fill |=> ($countones(holes) == $countones($past(holes)) - 1));

endmodule

// File: rtl/gaTourXover.sv
module gaTourXover
  import gaTourPkg::*;
#(
  parameter int N_CITY = 8,
  parameter int IDX_W  = $clog2(N_CITY),
  parameter int RND_W  = 16,
  parameter int NUM_RNG = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic                    mutEn,
  input  logic [N_CITY*IDX_W-1:0] parentA,
  input  logic [N_CITY*IDX_W-1:0] parentB,
  output logic                    done,
  output logic [N_CITY*IDX_W-1:0] child
);

  tourStrobe_t      ctl;
  logic             scanPending, scanLast, noHoles;
  logic [RND_W-1:0] rnd [NUM_RNG];

  for (genvar k = 0; k < NUM_RNG; k++) begin : g_rng
    gaLfsr #(
      .WIDTH(RND_W),
      .TAPS (RND_W'(16'hB400)),
      .SEED (RND_W'(16'hACE1 + 16'h3A5B * k))
    ) i_rng (
      .clk  (clk),
      .rstN (rstN),
      .value(rnd[k])
    );
  end

  gaTourCtrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .mutEn      (mutEn),
    .scanPending(scanPending),
    .scanLast   (scanLast),
    .noHoles    (noHoles),
    .ctl        (ctl),
    .done       (done)
  );

  gaTourPath #(
    .N_CITY(N_CITY),
    .IDX_W (IDX_W),
    .RND_W (RND_W)
  ) i_path (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .parentA    (parentA),
    .parentB    (parentB),
    .rndCut     (rnd[0]),
    .rndFill    (rnd[1]),
    .rndSwap    (rnd[2]),
    .child      (child),
    .scanPending(scanPending),
    .scanLast   (scanLast),
    .noHoles    (noHoles)
  );

  logic [N_CITY-1:0] seenCity;
  always_comb begin
    seenCity = '0;
    for (int i = 0; i < N_CITY; i++) seenCity[child[i*IDX_W +: IDX_W]] = 1'b1;
  end

  // R2
  child_perm_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (seenCity == '1));

endmodule

// File: tb/test_gaTourXover.sv
module test_gaTourXover;

  localparam int N = 8;
  localparam int W = 3;
  localparam int V = N * W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic mutEn = 1'b0;
  logic [V-1:0] parentA = '0, parentB = '0;
  logic done;
  logic [V-1:0] child;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  gaTourXover i_gaTourXover (
    .clk(clk), .rstN(rstN), .start(start), .mutEn(mutEn),
    .parentA(parentA), .parentB(parentB), .done(done), .child(child)
  );

  task automatic check(input bit ok, input string tag, input logic [V-1:0] act, input logic [V-1:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int gene(input logic [V-1:0] v, input int i);
    return int'(v[i*W +: W]);
  endfunction

  function automatic bit isPerm(input logic [V-1:0] v);
    logic [N-1:0] s = '0;
    for (int i = 0; i < N; i++) s[gene(v, i)] = 1'b1;
    return s == '1;
  endfunction

  function automatic bit cutFits(input logic [V-1:0] a, input logic [V-1:0] b, input logic [V-1:0] c);
    for (int cut = 0; cut < N; cut++) begin
      bit ok = 1;
      logic [N-1:0] used = '0;
      for (int i = 0; i <= cut; i++) begin
        if (gene(c, i) != gene(a, i)) ok = 0;
        used[gene(a, i)] = 1'b1;
      end
      for (int j = cut + 1; j < N; j++)
        if (!used[gene(b, j)] && gene(c, j) != gene(b, j)) ok = 0;
      if (ok) return 1;
    end
    return 0;
  endfunction

  function automatic logic [V-1:0] randPerm();
    int p[N];
    logic [V-1:0] v;
    for (int i = 0; i < N; i++) p[i] = i;
    for (int i = N - 1; i > 0; i--) begin
      int j = $urandom_range(i, 0);
      int t = p[i];
      p[i] = p[j];
      p[j] = t;
    end
    for (int i = 0; i < N; i++) v[i*W +: W] = W'(p[i]);
    return v;
  endfunction

  function automatic logic [V-1:0] identity();
    logic [V-1:0] v;
    for (int i = 0; i < N; i++) v[i*W +: W] = W'(i);
    return v;
  endfunction

  // Launch one operation and wait for done; also checks the pulse width (R8).
  task automatic runOp(input logic [V-1:0] a, input logic [V-1:0] b, input bit m, input int gap,
                       output logic [V-1:0] res);
    int t = 0;
    repeat (gap) @(negedge clk);
    parentA = a; parentB = b; mutEn = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && t < 200) begin @(negedge clk); t++; end
    res = child;
    check(done, "R8 done seen", {23'b0, done}, 1);
    @(negedge clk);
    check(!done, "R8 done single cycle", {23'b0, done}, 0);
  endtask

  task automatic testReset();
    check(done == 1'b0, "R1 done after reset", {23'b0, done}, 0);
    check(child == '0, "R1 child after reset", child, '0);
  endtask

  task automatic testEqualParents();
    logic [V-1:0] a, r;
    for (int k = 0; k < 6; k++) begin
      a = randPerm();
      runOp(a, a, 1'b0, k, r);
      check(r == a, "R7 equal parents no mutation", r, a);
      check(cutFits(a, a, r), "R3 head copied", r, a);
    end
  endtask

  task automatic testMutation();
    logic [V-1:0] a, r;
    for (int k = 0; k < 10; k++) begin
      int d = 0, p = -1, q = -1;
      a = randPerm();
      runOp(a, a, 1'b1, k % 5, r);
      for (int i = 0; i < N; i++)
        if (gene(r, i) != gene(a, i)) begin
          d++;
          if (p < 0) p = i; else q = i;
        end
      check(isPerm(r), "R2 mutated child is a tour", r, a);
      check(d == 0 || (d == 2 && gene(r, p) == gene(a, q) && gene(r, q) == gene(a, p)),
            "R6 swap of two positions", r, a);
    end
  endtask

  task automatic testRandomCross();
    logic [V-1:0] a, b, r;
    for (int k = 0; k < 20; k++) begin
      a = randPerm();
      b = randPerm();
      runOp(a, b, 1'b0, k % 7, r);
      check(isPerm(r), "R2 child is a tour", r, a);
      check(cutFits(a, b, r), "R4 free tail genes from second parent", r, b);
    end
  endtask

  task automatic testHoles();
    logic [V-1:0] a, b, r;
    for (int k = 0; k < 12; k++) begin
      a = identity();
      for (int i = 0; i < N; i++)
        b[i*W +: W] = (k % 2 == 0) ? W'(N - 1 - i) : W'((i + k) % N);
      runOp(a, b, 1'b0, k, r);
      check(isPerm(r), "R5 holes filled with unused cities", r, a);
      check(cutFits(a, b, r), "R3 head kept with many holes", r, a);
    end
  endtask

  task automatic testBusyStart();
    logic [V-1:0] a, b;
    int dones = 0;
    a = identity();
    b = randPerm();
    @(negedge clk);
    parentA = a; parentB = b; mutEn = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int t = 0; t < 60; t++) begin
      if (done) dones++;
      @(negedge clk);
    end
    check(dones == 1, "R8 start while busy ignored", V'(dones), 1);
  endtask

  task automatic testHold();
    logic [V-1:0] r, held;
    runOp(randPerm(), randPerm(), 1'b1, 1, r);
    held = child;
    for (int t = 0; t < 10; t++) begin
      parentA = randPerm(); parentB = randPerm(); mutEn = t[0];
      @(negedge clk);
    end
    check(child == held, "R9 child stable between operations", child, held);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testEqualParents();
    testMutation();
    testRandomCross();
    testHoles();
    testBusyStart();
    testHold();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule